// File: doc/BRIEF.md
# Serial BCD to Excess-3 Converter

This block turns a stream of decimal digits, each sent as four bits on one wire with the least significant bit first, into the matching Excess-3 code on a second wire. Each output bit is the sum bit of the digit plus three at that bit position. It appears in the same clock cycle as the input bit that produced it, because the output is a Mealy function of the current input and the stored state.

The addition is done one bit per clock. A seven-state machine carries the add-three state from one bit to the next: which bit position comes next and whether a carry is pending into it. After the fourth bit the machine is back in its start state, so digits can follow one another with no gap and no framing signal. A synchronous active-low reset puts the machine back at the start of a digit at any point.

Top module: `serial_excess3`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters the start state. In that state `z_out` equals the inverse of `x_in`, so the bit presented first reads as 0 + 3 at bit 0.
- R2: For every BCD digit d from 0 to 9 sent as bits d[0], d[1], d[2], d[3] on four consecutive cycles, `z_out` in those cycles is bits 0 to 3 of d + 3.
- R3: Digits may follow each other with no idle cycle. After the fourth bit of a digit has been clocked in, the machine is always back in the start state, and the next cycle converts bit 0 of the next digit.
- R4: `z_out` depends combinationally on `x_in` within a cycle. Changing `x_in` between clock edges changes `z_out` at once.
- R5: Reset has priority over every transition. A low `rst_n` at an edge in the middle of a digit, whatever the value of `x_in`, discards the partial digit. The next cycle converts bit 0 of a new digit.
- R6: The state register holds only the seven codes 000, 001, 011, 110, 100, 111, 101 ([2:0]). Code 010 is never entered after reset, and if it were present it would lead to the start state on the next clock.
- R7: The four-bit codes 10 to 15 are converted to (d + 3) mod 16 LSB first. In particular, the fourth bit of 13, 14 and 15 gives 0, and the machine returns to the start state with no disturbance to the following digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock, one serial bit per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| x_in | input | 1 | Serial BCD input, least significant bit of each digit first |
| z_out | output | 1 | Serial Excess-3 output, valid in the same cycle as `x_in` |

## Verification
Two events can fall in the same cycle: reset and a normal state step. This includes the step that closes a digit and returns to the start state. The bench drives `rst_n` low with `x_in` high, once two bits into a digit and once on its fourth bit. In the cycle after reset is released, it sends a fresh digit and compares all four output bits with the sum computed in the bench. Every one of the sixteen four-bit codes is also sent back to back and compared with (d + 3) mod 16, so the end-of-digit return is exercised on every path through the machine.

// File: rtl/x3s_pkg.sv
// Package: shared constants and the state type of the serial Excess-3 converter.
// Assumes: digits are four bits wide and arrive LSB first.
package x3s_pkg;

    localparam int DIGIT_BITS = 4;
    localparam int ADD_VALUE  = 3;
    localparam int STATE_W    = 3;

    // Each state names the bit position to be processed next and whether a
    // carry is pending into it. The encodings are fixed because the reduced
    // next-state and output equations depend on them.
    typedef enum logic [STATE_W-1:0] {
        ST_BIT0        = 3'b000,
        ST_BIT1_PLAIN  = 3'b001,
        ST_BIT1_CARRY  = 3'b011,
        ST_BIT2_PLAIN  = 3'b110,
        ST_BIT2_CARRY  = 3'b100,
        ST_BIT3_PLAIN  = 3'b111,
        ST_BIT3_CARRY  = 3'b101
    } x3s_state_t;

    localparam logic [STATE_W-1:0] UNUSED_CODE = 3'b010;

endpackage

// File: rtl/x3s_next_state.sv
// Module: next-state logic of the serial adder.
// Does: picks the following state from the current state and input bit.
// Assumes: the unused code 010 and the non-BCD case (bit 3 with a carry
// and x=1) both lead back to the start state.
module x3s_next_state
    import x3s_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    input  logic               bit_in,
    output logic [STATE_W-1:0] nxt_state
);

    // Transition table: one step of adding three, one bit at a time.
    always_comb begin
        unique case (cur_state)
            ST_BIT0:       nxt_state = bit_in ? ST_BIT1_CARRY : ST_BIT1_PLAIN;
            ST_BIT1_PLAIN: nxt_state = bit_in ? ST_BIT2_CARRY : ST_BIT2_PLAIN;
            ST_BIT1_CARRY: nxt_state = ST_BIT2_CARRY;
            ST_BIT2_PLAIN: nxt_state = ST_BIT3_PLAIN;
            ST_BIT2_CARRY: nxt_state = bit_in ? ST_BIT3_CARRY : ST_BIT3_PLAIN;
            ST_BIT3_PLAIN: nxt_state = ST_BIT0;
            ST_BIT3_CARRY: nxt_state = ST_BIT0;
            default:       nxt_state = ST_BIT0;
        endcase
    end

endmodule

// File: rtl/x3s_output.sv
// Module: Mealy output of the serial adder.
// Does: gives the sum bit for the current position. With the fixed encoding,
// state bit 1 is set exactly when the sum bit equals the input bit.
// Assumes: the state encodings of x3s_pkg.
module x3s_output
    import x3s_pkg::*;
(
    input  logic [STATE_W-1:0] cur_state,
    input  logic               bit_in,
    output logic               sum_bit
);

    // Sum bit: copy the input when state bit 1 is set, invert it otherwise.
    always_comb begin
        sum_bit = cur_state[1] ? bit_in : ~bit_in;
    end

endmodule

// File: rtl/x3s_state_reg.sv
// Module: state register with synchronous active-low reset.
// Does: stores the converter state. Reset wins over any next-state value.
// Assumes: the reset is synchronous to clk.
module x3s_state_reg
    import x3s_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STATE_W-1:0] d_state,
    output logic [STATE_W-1:0] q_state
);

    // Register: load the next state, or the start state while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q_state <= ST_BIT0;
        else        q_state <= d_state;
    end

    // R5: reset forces the start state on the following cycle.
    a_r5_reset_forces_start: assert property (@(posedge clk)
        !rst_n |=> q_state == ST_BIT0);

endmodule

// File: rtl/serial_excess3.sv
// Module: serial BCD to Excess-3 converter (top).
// Does: adds three to each LSB-first four-bit digit on x_in and drives the
// sum bits on z_out in the same cycle (Mealy output).
// Assumes: digits follow back to back. Reset is synchronous and active low.
module serial_excess3
    import x3s_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic x_in,
    output logic z_out
);

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] state_d;

    x3s_next_state u_next (
        .cur_state (state_q),
        .bit_in    (x_in),
        .nxt_state (state_d)
    );

    x3s_state_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_state (state_d),
        .q_state (state_q)
    );

    x3s_output u_out (
        .cur_state (state_q),
        .bit_in    (x_in),
        .sum_bit   (z_out)
    );

    // Checker counter: bit position within the current digit, counted on its own.
    logic [1:0] chk_pos;
    always_ff @(posedge clk) begin
        if (!rst_n) chk_pos <= '0;
        else        chk_pos <= chk_pos + 2'd1;
    end

    // R3: the start state coincides with bit position 0 of every digit.
    a_r3_frame_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_pos == 2'd0) == (state_q == ST_BIT0));

    // R6: the unused code is never held after reset.
    a_r6_no_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != UNUSED_CODE);

    // R7: both last-bit states return to the start state.
    a_r7_last_bit_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT3_PLAIN || state_q == ST_BIT3_CARRY) |=> state_q == ST_BIT0);

    // R1: in the start state the output is the inverse of the input.
    a_r1_start_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BIT0) |-> (z_out != x_in));

endmodule

// File: tb/serial_excess3_test.sv
module serial_excess3_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic x_in = 1'b0;
    logic z_out;

    int vectors = 0;
    int misses = 0;
    bit done = 1'b0;

    serial_excess3 uut (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_in),
        .z_out (z_out)
    );

    always #2.5 clk = ~clk;

    // Compare the output with an expected value. Called away from the clock edge.
    task automatic check(input logic exp, input string tag);
        vectors++;
        if (z_out !== exp) begin
            misses++;
            $display("FAIL %s: z_out=%b expected=%b at %0t", tag, z_out, exp, $time);
        end
    endtask

    // Drive one bit from a negedge, check it, and end on the next negedge.
    task automatic send_bit(input logic b, input logic exp, input string tag);
        x_in = b;
        #1;
        check(exp, tag);
        @(negedge clk);
    endtask

    // Send one four-bit code LSB first and expect (d+3) mod 16.
    task automatic send_digit(input int d, input string tag);
        logic [3:0] code;
        logic [3:0] sum;
        code = 4'(d);
        sum  = 4'(d + 3);
        for (int i = 0; i < 4; i++) send_bit(code[i], sum[i], tag);
    endtask

    // One reset cycle with x high, starting and ending on a negedge.
    task automatic pulse_reset();
        rst_n = 1'b0;
        x_in  = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1: start state after reset, output is the inverted input.
        x_in = 1'b0; #1; check(1'b1, "R1 reset state x=0");
        // R4: change x with no clock edge, z follows at once.
        x_in = 1'b1; #1; check(1'b0, "R4 mealy x=1");
        x_in = 1'b0; #1; check(1'b1, "R4 mealy x=0");
        @(negedge clk);
        pulse_reset();
        // R2 and R3: all ten BCD digits back to back.
        for (int d = 0; d < 10; d++) send_digit(d, "R2 R3 bcd digit");
        // R7: non-BCD codes, followed by normal digits to show recovery.
        for (int d = 10; d < 16; d++) send_digit(d, "R7 non-bcd code");
        send_digit(0, "R7 recovery");
        send_digit(7, "R7 recovery");
        // R5: reset after two bits of digit 9, then a fresh digit.
        send_bit(1'b1, 1'b0, "R5 partial");
        send_bit(1'b0, 1'b0, "R5 partial");
        pulse_reset();
        send_digit(4, "R5 after mid-digit reset");
        // R5: reset in the cycle of the last bit, together with the return to start.
        send_bit(1'b0, 1'b1, "R5 partial");
        send_bit(1'b0, 1'b1, "R5 partial");
        send_bit(1'b0, 1'b0, "R5 partial");
        pulse_reset();
        send_digit(2, "R5 after last-bit reset");
        // R6: states stay legal over a second sweep with every code.
        for (int d = 15; d >= 0; d--) send_digit(d, "R6 reverse sweep");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            misses++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule